// File: doc/BRIEF.md
# Memory Bus Turnaround Gap Inserter

This block sits between the transaction sequencer of an external memory controller and the data bus shared by several memory devices. When the bus changes direction or passes between static and dynamic memory, it holds back the next access for a programmable number of idle cycles. This keeps one device's output drivers from overlapping another's. The block decides only when an access may begin. Pin signalling and device command timing are handled elsewhere.

Each of the four static chip selects has its own turnaround count register, reached through a word-wide register port. The sequencer raises a request that carries a chip select, a direction and a memory type, and keeps it stable until it is granted. The block compares the request with the access it last granted. It either grants the request in the same cycle or first counts out a gap, during which a busy flag is raised. The count registers can only be changed while the controller is quiescent, which the surrounding controller signals on a dedicated input.

Top module: `bus_turn_gap`

## Requirements
- R1: Register index 0 to 3 on `cfg_addr` selects the count register of static chip select 0 to 3. Indices 4 to 7 read as zero, and a write to them changes no register.
- R2: The count field is `cfg_wdata[3:0]` and `cfg_rdata[3:0]`. Read data bits 31:4 are always zero, and written values in those bits are discarded.
- R3: After reset every count register reads 0xF.
- R4: A register write is accepted only in a cycle with `cfg_wr` = 1 and `ctl_quiet` = 1. With `ctl_quiet` = 0 the register keeps its old value.
- R5: The first request after reset is granted in the cycle it is presented, with no gap.
- R6: A static write (`req_dyn` = 0, `req_write` = 1) that follows a static read to the same chip select is granted N = count+1 cycles after it is first presented, where count is that chip select's register. N ranges from 1 to 16.
- R7: A change between static and dynamic memory, in either order, inserts N cycles. Static-to-dynamic uses the register of the previous static chip select. Dynamic-to-static uses the register of the incoming chip select.
- R8: No gap is inserted for a static write followed by a static read, for two static accesses in the same direction, or for two dynamic accesses. The grant comes in the cycle the request is presented.
- R9: A static read-to-write change between different chip selects takes its length from the register of the chip select that performed the read.
- R10: `gap_busy` is 1 in every cycle a presented request is held off and 0 in the cycle it is granted. `req_grant` is never 1 while `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register at `cfg_addr` (combinational) |
| ctl_quiet | input | 1 | Controller quiescent (low-power or disabled); enables register writes |
| req_valid | input | 1 | Sequencer requests an access |
| req_cs | input | 2 | Chip select of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dyn | input | 1 | 1 = dynamic memory, 0 = static memory |
| req_grant | output | 1 | Access may start this cycle |
| gap_busy | output | 1 | A turnaround gap is being counted |

## Verification
The main function is swept over every ordered pair of the sixteen possible accesses (four chip selects, two directions, two memory types). The registers are loaded with distinct counts that include the minimum 0 and the maximum 15. This lets the bench tell which chip select's register supplied the gap length. It also separates read-to-write from write-to-read, and distinguishes a type change in each direction from repeated accesses to the same type. The register port is tried with reserved bits set, with out-of-range indices, and with writes while the controller is busy. Each of these is followed by a read-back that shows whether a stored value was disturbed.

// File: rtl/btg_pkg.sv
package btg_pkg;

  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_HOLD = 1'b1
  } gap_state_e;

  // Decide whether the bus needs idle cycles before the next access.
  function automatic logic gap_needed(
    input logic have_prev,
    input logic prev_wr,
    input logic prev_dyn,
    input logic next_wr,
    input logic next_dyn
  );
    logic kind_change;
    logic rd_to_wr;
    kind_change = prev_dyn ^ next_dyn;
    rd_to_wr    = !prev_dyn && !next_dyn && !prev_wr && next_wr;
    return have_prev && (kind_change || rd_to_wr);
  endfunction

  // True when the incoming chip select owns the gap length.
  function automatic logic use_incoming_cs(
    input logic prev_dyn,
    input logic next_dyn
  );
    return prev_dyn && !next_dyn;
  endfunction

  // Idle cycles that a programmed field value stands for.
  function automatic int unsigned turn_cycles(input int unsigned field);
    return field + 1;
  endfunction

endpackage

// File: rtl/btg_regfile.sv
module btg_regfile #(
  parameter int NUM_CS    = 4,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int RESET_CNT = 15,
  localparam int IDX_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    quiet,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [CNT_W-1:0]        wfield,
  output logic [DATA_W-1:0]       rdata,
  input  logic [IDX_W-1:0]        lut_cs,
  output logic [CNT_W-1:0]        lut_cnt,
  output logic [NUM_CS*CNT_W-1:0] cnt_flat
);

  logic [CNT_W-1:0] cnt_q [NUM_CS];
  logic             addr_hit;
  logic [IDX_W-1:0] addr_idx;
  logic             wr_accept;

  assign addr_hit  = (int'(addr) < NUM_CS);
  assign addr_idx  = addr[IDX_W-1:0];
  assign wr_accept = wr_en && quiet && addr_hit;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i] <= CNT_W'(RESET_CNT);
      end else if (wr_accept && (addr_idx == IDX_W'(i))) begin
        cnt_q[i] <= wfield;
      end
    end
    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
  end

  always_comb begin
    rdata = '0;
    if (addr_hit) begin
      rdata[CNT_W-1:0] = cnt_q[addr_idx];
    end
  end

  assign lut_cnt = cnt_q[lut_cs];

endmodule

// File: rtl/btg_history.sv
module btg_history #(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant,
  input  logic [CS_W-1:0] req_cs,
  input  logic            req_wr,
  input  logic            req_dyn,
  output logic            have_prev,
  output logic [CS_W-1:0] prev_cs,
  output logic            prev_wr,
  output logic            prev_dyn
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_cs   <= '0;
      prev_wr   <= 1'b0;
      prev_dyn  <= 1'b0;
    end else if (grant) begin
      have_prev <= 1'b1;
      prev_cs   <= req_cs;
      prev_wr   <= req_wr;
      prev_dyn  <= req_dyn;
    end
  end

endmodule

// File: rtl/btg_gap_timer.sv
module btg_gap_timer
  import btg_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             need,
  input  logic [LEN_W-1:0] len,
  output logic             grant,
  output logic             busy
);

  gap_state_e       state_q;
  logic [LEN_W-1:0] left_q;
  logic             start_gap;

  assign start_gap = (state_q == ST_OPEN) && req_valid && need;

  always_comb begin
    if (state_q == ST_OPEN) begin
      grant = req_valid && !need;
      busy  = start_gap;
    end else begin
      grant = req_valid && (left_q == '0);
      busy  = (left_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      left_q  <= '0;
    end else if (start_gap) begin
      state_q <= ST_HOLD;
      left_q  <= len - LEN_W'(1);
    end else if (state_q == ST_HOLD) begin
      if (left_q != '0) begin
        left_q <= left_q - LEN_W'(1);
      end else if (grant) begin
        state_q <= ST_OPEN;
      end
    end
  end

endmodule

// File: rtl/bus_turn_gap.sv
module bus_turn_gap
  import btg_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int RESET_CNT = 15,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LEN_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ctl_quiet,
  input  logic              req_valid,
  input  logic [CS_W-1:0]   req_cs,
  input  logic              req_write,
  input  logic              req_dyn,
  output logic              req_grant,
  output logic              gap_busy
);

  // Named internal events, visible to the bound checker.
  logic                    have_prev;
  logic [CS_W-1:0]         prev_cs;
  logic                    prev_wr;
  logic                    prev_dyn;
  logic                    need_gap;
  logic [CS_W-1:0]         len_cs;
  logic [CNT_W-1:0]        len_field;
  logic [LEN_W-1:0]        gap_len;
  logic [NUM_CS*CNT_W-1:0] btc_flat;
  logic                    unused_wdata_hi;

  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:CNT_W];

  btg_regfile #(
    .NUM_CS   (NUM_CS),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RESET_CNT(RESET_CNT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .quiet   (ctl_quiet),
    .addr    (cfg_addr),
    .wfield  (cfg_wdata[CNT_W-1:0]),
    .rdata   (cfg_rdata),
    .lut_cs  (len_cs),
    .lut_cnt (len_field),
    .cnt_flat(btc_flat)
  );

  btg_history #(.CS_W(CS_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (req_grant),
    .req_cs   (req_cs),
    .req_wr   (req_write),
    .req_dyn  (req_dyn),
    .have_prev(have_prev),
    .prev_cs  (prev_cs),
    .prev_wr  (prev_wr),
    .prev_dyn (prev_dyn)
  );

  assign need_gap = gap_needed(have_prev, prev_wr, prev_dyn, req_write, req_dyn);
  assign len_cs   = use_incoming_cs(prev_dyn, req_dyn) ? req_cs : prev_cs;
  assign gap_len  = LEN_W'(turn_cycles(int'(len_field)));

  btg_gap_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .need     (need_gap),
    .len      (gap_len),
    .grant    (req_grant),
    .busy     (gap_busy)
  );

endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ctl_quiet,
  input logic                    req_valid,
  input logic                    req_grant,
  input logic                    gap_busy,
  input logic                    have_prev,
  input logic                    need_gap,
  input logic [DATA_W-1:0]       cfg_rdata,
  input logic [NUM_CS*CNT_W-1:0] btc_flat
);

  localparam int MAX_GAP = 1 << CNT_W;

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else if (gap_busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:CNT_W] == '0);

  p_locked_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_quiet |=> $stable(btc_flat));

  p_first_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !have_prev) |-> req_grant);

  p_gap_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= MAX_GAP);

  p_no_gap_case_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !need_gap && !gap_busy) |-> req_grant);

  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_grant && gap_busy));

  p_grant_has_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> req_valid);

endmodule

bind bus_turn_gap btg_checker #(
  .NUM_CS(NUM_CS),
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_quiet(ctl_quiet),
  .req_valid(req_valid),
  .req_grant(req_grant),
  .gap_busy (gap_busy),
  .have_prev(have_prev),
  .need_gap (need_gap),
  .cfg_rdata(cfg_rdata),
  .btc_flat (btc_flat)
);

// File: tb/test_bus_turn_gap.sv
module test_bus_turn_gap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ctl_quiet = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cs = '0;
  logic        req_write = 1'b0;
  logic        req_dyn = 1'b0;
  logic        req_grant;
  logic        gap_busy;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of the registers and of the last granted access.
  int m_cnt [4];
  bit m_have = 0;
  int m_cs = 0;
  bit m_wr = 0;
  bit m_dyn = 0;

  always #5 clk = ~clk;

  bus_turn_gap i_bus_turn_gap (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctl_quiet(ctl_quiet),
    .req_valid(req_valid), .req_cs(req_cs), .req_write(req_write),
    .req_dyn(req_dyn), .req_grant(req_grant), .gap_busy(gap_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] data, input bit quiet);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'(idx); cfg_wdata = data; ctl_quiet = quiet;
    @(negedge clk);
    cfg_wr = 1'b0; ctl_quiet = 1'b1;
  endtask

  task automatic reg_rd(input int idx, output int data);
    @(negedge clk);
    cfg_addr = 3'(idx);
    #1 data = int'(cfg_rdata);
  endtask

  // Expected idle cycles, from the requirements.
  function automatic int exp_wait(input int cs, input bit wr, input bit dyn);
    if (!m_have) return 0;
    if (m_dyn && !dyn) return m_cnt[cs] + 1;
    if (!m_dyn && dyn) return m_cnt[m_cs] + 1;
    if (!m_dyn && !dyn && !m_wr && wr) return m_cnt[m_cs] + 1;
    return 0;
  endfunction

  function automatic string tag_of(input int cs, input bit wr, input bit dyn);
    if (!m_have) return "R5";
    if (m_dyn != dyn) return "R7";
    if (!m_dyn && !m_wr && wr) return (m_cs != cs) ? "R9" : "R6";
    return "R8";
  endfunction

  task automatic access(input int cs, input bit wr, input bit dyn);
    int exp;
    int waits;
    bit busy_ok;
    string tag;
    exp = exp_wait(cs, wr, dyn);
    tag = tag_of(cs, wr, dyn);
    @(negedge clk);
    req_valid = 1'b1; req_cs = 2'(cs); req_write = wr; req_dyn = dyn;
    #1;
    waits = 0;
    busy_ok = 1;
    while (!req_grant && waits < 40) begin
      if (!gap_busy) busy_ok = 0;
      @(negedge clk);
      #1;
      waits++;
    end
    check(waits == exp, tag, waits, exp);
    check(busy_ok && !gap_busy, "R10", int'(gap_busy), 0);
    m_have = 1; m_cs = cs; m_wr = wr; m_dyn = dyn;
    @(negedge clk);
    req_valid = 1'b0;
    #1 check(!req_grant, "R10", int'(req_grant), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    int rd;
    int prog [4];
    prog[0] = 3; prog[1] = 0; prog[2] = 9; prog[3] = 15;
    for (int i = 0; i < 4; i++) m_cnt[i] = 15;
    repeat (3) @(negedge clk);
    #1 check(!req_grant && !gap_busy, "R10", int'(req_grant), 0);
    rst_n = 1'b1;

    // R3 reset values and R1 out-of-range reads
    for (int i = 0; i < 8; i++) begin
      reg_rd(i, rd);
      check(rd == ((i < 4) ? 15 : 0), (i < 4) ? "R3" : "R1", rd, (i < 4) ? 15 : 0);
    end

    // R5 first access after reset is free
    access(1, 1, 0);

    // R2 reserved bits discarded
    reg_wr(2, 32'hFFFF_FFF5, 1);
    reg_rd(2, rd);
    check(rd == 5, "R2", rd, 5);

    // R4 write while busy rejected
    reg_wr(2, 32'h0000_0007, 0);
    reg_rd(2, rd);
    check(rd == 5, "R4", rd, 5);

    // R1 write to an unused index changes nothing
    reg_wr(5, 32'h0000_0001, 1);
    reg_rd(5, rd);
    check(rd == 0, "R1", rd, 0);
    for (int i = 0; i < 4; i++) begin
      reg_rd(i, rd);
      check(rd == ((i == 2) ? 5 : 15), "R1", rd, (i == 2) ? 5 : 15);
    end

    // Program distinct counts and read back (R1, R4)
    for (int i = 0; i < 4; i++) begin
      reg_wr(i, 32'(prog[i]), 1);
      m_cnt[i] = prog[i];
    end
    for (int i = 0; i < 4; i++) begin
      reg_rd(i, rd);
      check(rd == prog[i], "R4", rd, prog[i]);
    end

    // Sweep every ordered pair of accesses (R6, R7, R8, R9, R10)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        access(a % 4, (a / 4) % 2 == 1, a / 8 == 1);
        access(b % 4, (b / 4) % 2 == 1, b / 8 == 1);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule